// File: doc/BRIEF.md
# Link Transmit Write Front-End

This block sits on the sending side of a 64-bit word link. A user writes words through a synchronous port with an active-low write strobe. Each word carries one extra marker bit that tags it as control or data. The block first trims each accepted word to the selected data width. It then queues the word in a show-ahead FIFO and offers it on a parallel transmit port that the link side drains with a ready signal.

An active-low full flag tells the user to stop writing. The flag has two causes. The local cause is the FIFO running low on free space. The remote cause is a flow-stop code arriving on the return channel; a flow-resume code clears it. The flag rises early enough that at least 16 more writes always fit after it falls. Writes that reach a completely full FIFO are thrown away and latch a sticky overflow indicator.

A test mode replaces the queued traffic with an incrementing 64-bit counter, sent with the marker bit clear. The FIFO contents are left untouched while test mode is active.

Top module: `lsrc_front`

## Requirements
- R1: After a synchronous active-high reset, `full_n` is 1, `tx_valid` is 0, `ovf` is 0, the FIFO is empty, any flow-stop state is cleared and the test counter restarts at 0.
- R2: A word is captured on a rising clock edge only when `wr_n` is 0. Captured words leave on `tx_data`/`tx_ctrl` in write order, with their marker bit, one word per edge on which `tx_ready` is 1. No word is captured while `wr_n` is 1.
- R3: `width_sel` trims the captured word. 2'b11 keeps all 64 bits. 2'b00 keeps bits 31:0, 2'b01 keeps bits 15:0 and 2'b10 keeps bits 7:0. All other bits are sent as zero.
- R4: With no flow-stop state, `full_n` is 0 exactly when the FIFO holds `DEPTH-HEADROOM` (48) or more words, that is, when 16 or fewer entries are free.
- R5: Once `full_n` has fallen because of FIFO occupancy, 16 further writes are accepted and later transmitted without loss.
- R6: A write made while the FIFO holds `DEPTH` words is discarded, and `ovf` becomes 1 and stays 1 until reset.
- R7: A flow-stop code (`fc_valid`=1, `fc_stop`=1) drives `full_n` to 0 from the next cycle on. A flow-resume code (`fc_valid`=1, `fc_stop`=0) releases it, but `full_n` stays 0 while the local cause of R4 holds.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, the offered word and marker bit do not change.
- R9: While `test_n` is 0, `tx_valid` is 1 and `tx_ctrl` is 0. `tx_data` carries a counter that advances by one on each edge with `tx_ready` at 1. The FIFO is neither drained nor altered by test-mode transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| wr_ctrl | input | 1 | Marker bit of the written word |
| wr_data | input | 64 | Written word |
| width_sel | input | 2 | Data width code |
| test_n | input | 1 | Test mode, active low |
| fc_valid | input | 1 | Return-channel flow code present |
| fc_stop | input | 1 | 1 = flow-stop code, 0 = flow-resume code |
| tx_ready | input | 1 | Link side takes the offered word |
| tx_valid | output | 1 | A word is offered |
| tx_ctrl | output | 1 | Marker bit of the offered word |
| tx_data | output | 64 | Offered word |
| full_n | output | 1 | Full flag, active low |
| ovf | output | 1 | Sticky overflow indicator |

## Verification
The stall-hold and counter-step properties assume that `test_n` is held for whole cycles, and they make no claim across a mode change. The bench changes `test_n` only while `tx_ready` is 0. The reset property assumes that reset is applied at time zero, and the bench starts with reset high. The flow properties assume that a flow code is a one-cycle pulse. The bench never drives a flow code in the same cycle as reset, so the flow-stop register takes each code on its own edge.

// File: rtl/lsrc_pkg.sv
package lsrc_pkg;

    localparam int DATA_W = 64;

    typedef struct packed {
        logic              ctrl;
        logic [DATA_W-1:0] data;
    } lword_t;

    typedef enum logic [1:0] {
        WSEL_32 = 2'b00,
        WSEL_16 = 2'b01,
        WSEL_8  = 2'b10,
        WSEL_64 = 2'b11
    } wsel_e;

    function automatic logic [DATA_W-1:0] trim_word(input logic [1:0] sel,
                                                     input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] ones;
        ones = '1;
        case (wsel_e'(sel))
            WSEL_32: return d & (ones >> (DATA_W - 32));
            WSEL_16: return d & (ones >> (DATA_W - 16));
            WSEL_8:  return d & (ones >> (DATA_W - 8));
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/lsrc_fifo.sv
module lsrc_fifo
    import lsrc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_req,
    input  lword_t                       wr_word,
    input  logic                         rd_req,
    output lword_t                       head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    lword_t          mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            do_push, do_pop;

    assign do_push = wr_req && (count != CNT_FULL);
    assign do_pop  = rd_req && (count != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_req && !do_push) ovf <= 1'b1;
        end
    end

    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_req && count == CNT_FULL) |=> ovf) else $error("drop flag"); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf) else $error("ovf sticky"); // R6

endmodule

// File: rtl/lsrc_flow.sv
module lsrc_flow #(
    parameter int DEPTH    = 64,
    parameter int HEADROOM = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH+1)-1:0]   count,
    input  logic                         fc_valid,
    input  logic                         fc_stop,
    output logic                         full_n
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH - HEADROOM);

    logic stop_q;
    logic near_full;

    always_ff @(posedge clk) begin
        if (rst)           stop_q <= 1'b0;
        else if (fc_valid) stop_q <= fc_stop;
    end

    assign near_full = (count >= LIMIT);
    assign full_n    = !(near_full || stop_q);

    AST_STOP_CODE: assert property (@(posedge clk) disable iff (rst)
        (fc_valid && fc_stop) |=> !full_n) else $error("stop code"); // R7
    AST_RESUME_CODE: assert property (@(posedge clk) disable iff (rst)
        (fc_valid && !fc_stop) |=> !stop_q) else $error("resume code"); // R7

endmodule

// File: rtl/lsrc_testgen.sv
module lsrc_testgen
    import lsrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [DATA_W-1:0] pattern
);
    always_ff @(posedge clk) begin
        if (rst)          pattern <= '0;
        else if (advance) pattern <= pattern + 1'b1;
    end
endmodule

// File: rtl/lsrc_front.sv
module lsrc_front
    import lsrc_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HEADROOM = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              wr_ctrl,
    input  logic [63:0]       wr_data,
    input  logic [1:0]        width_sel,
    input  logic              test_n,
    input  logic              fc_valid,
    input  logic              fc_stop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic              tx_ctrl,
    output logic [63:0]       tx_data,
    output logic              full_n,
    output logic              ovf
);
    localparam int CW = $clog2(DEPTH+1);

    lword_t            in_word, head;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] pattern;
    logic              test_on;

    assign test_on      = !test_n;
    assign in_word.ctrl = wr_ctrl;
    assign in_word.data = trim_word(width_sel, wr_data);

    lsrc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .wr_req (!wr_n),
        .wr_word(in_word),
        .rd_req (tx_ready && !test_on),
        .head   (head),
        .count  (count),
        .ovf    (ovf)
    );

    lsrc_flow #(.DEPTH(DEPTH), .HEADROOM(HEADROOM)) u_flow (
        .clk     (clk),
        .rst     (rst),
        .count   (count),
        .fc_valid(fc_valid),
        .fc_stop (fc_stop),
        .full_n  (full_n)
    );

    lsrc_testgen u_tgen (
        .clk    (clk),
        .rst    (rst),
        .advance(test_on && tx_ready),
        .pattern(pattern)
    );

    always_comb begin
        if (test_on) begin
            tx_valid = 1'b1;
            tx_ctrl  = 1'b0;
            tx_data  = pattern;
        end else begin
            tx_valid = (count != '0);
            tx_ctrl  = head.ctrl;
            tx_data  = head.data;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (full_n && !ovf)) else $error("reset state"); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && test_n) |=>
            (!test_n || (tx_valid && $stable(tx_data) && $stable(tx_ctrl))))
        else $error("stall hold"); // R8
    AST_TEST_STEP: assert property (@(posedge clk) disable iff (rst)
        (!test_n && tx_ready) |=> (test_n || tx_data == $past(tx_data) + 64'd1))
        else $error("test step"); // R9

endmodule

// File: tb/lsrc_front_tb.sv
module lsrc_front_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1, wr_ctrl = 1'b0;
    logic [63:0] wr_data = '0;
    logic [1:0]  width_sel = 2'b11;
    logic        test_n = 1'b1, fc_valid = 1'b0, fc_stop = 1'b0, tx_ready = 1'b0;
    logic        tx_valid, tx_ctrl, full_n, ovf;
    logic [63:0] tx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lsrc_front u_dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .width_sel(width_sel), .test_n(test_n), .fc_valid(fc_valid), .fc_stop(fc_stop),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_ctrl(tx_ctrl), .tx_data(tx_data),
        .full_n(full_n), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [63:0] d, input logic c, input logic [1:0] ws);
        wr_n = 1'b0; wr_data = d; wr_ctrl = c; width_sel = ws;
        tick();
        wr_n = 1'b1;
    endtask

    task automatic take(input string req, input logic [63:0] d, input logic c);
        #0.5;
        chk(req, {63'd0, tx_valid}, 64'd1);
        chk(req, tx_data, d);
        chk(req, {63'd0, tx_ctrl}, {63'd0, c});
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
    endtask

    task automatic code(input logic stop);
        fc_valid = 1'b1; fc_stop = stop;
        tick();
        fc_valid = 1'b0;
    endtask

    function automatic logic [63:0] trimmed(input logic [1:0] ws, input logic [63:0] d);
        int w;
        w = (ws == 2'b11) ? 64 : (ws == 2'b10) ? 8 : (ws == 2'b01) ? 16 : 32;
        return (w == 64) ? d : (d & ((64'd1 << w) - 64'd1));
    endfunction

    function automatic logic [63:0] pat(input int i);
        return 64'hF0E1_D2C3_B4A5_9687 ^ (64'(i) * 64'h0101_0101_0101_0101);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #0.5;
        // R1 reset state
        chk("R1", {63'd0, full_n}, 64'd1);
        chk("R1", {63'd0, tx_valid}, 64'd0);
        chk("R1", {63'd0, ovf}, 64'd0);

        // R2 no capture while strobe high
        for (int i = 0; i < 4; i++) begin
            wr_data = pat(i); wr_n = 1'b1;
            tick();
        end
        chk("R2", {63'd0, tx_valid}, 64'd0);

        // R2 R3 order, marker bit and width trimming for every width code
        for (int ws = 0; ws < 4; ws++)
            for (int k = 0; k < 3; k++)
                put(pat(ws * 3 + k), k[0], 2'(ws));
        for (int ws = 0; ws < 4; ws++)
            for (int k = 0; k < 3; k++)
                take("R3", trimmed(2'(ws), pat(ws * 3 + k)), k[0]);
        chk("R2", {63'd0, tx_valid}, 64'd0);

        // R8 stall: head holds while not ready
        put(64'hAAAA_5555_0000_FFFF, 1'b1, 2'b11);
        put(64'h1234, 1'b0, 2'b11);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8", tx_data, 64'hAAAA_5555_0000_FFFF);
        end
        take("R8", 64'hAAAA_5555_0000_FFFF, 1'b1);
        take("R2", 64'h1234, 1'b0);

        // R4 flag versus occupancy sweep, R5 headroom, R6 overflow
        for (int i = 0; i < 64; i++) begin
            chk("R4", {63'd0, full_n}, (i < 48) ? 64'd1 : 64'd0);
            put(64'(i), i[0], 2'b11);
        end
        chk("R4", {63'd0, full_n}, 64'd0);
        chk("R6", {63'd0, ovf}, 64'd0);
        for (int i = 0; i < 3; i++) put(64'hDEAD_0000 + 64'(i), 1'b1, 2'b11);
        chk("R6", {63'd0, ovf}, 64'd1);
        for (int i = 0; i < 64; i++) take("R5", 64'(i), i[0]);
        chk("R6", {63'd0, tx_valid}, 64'd0);
        chk("R6", {63'd0, ovf}, 64'd1);
        chk("R4", {63'd0, full_n}, 64'd1);

        // R7 remote stop and resume
        code(1'b1);
        chk("R7", {63'd0, full_n}, 64'd0);
        code(1'b0);
        chk("R7", {63'd0, full_n}, 64'd1);
        for (int i = 0; i < 50; i++) put(64'(i + 100), 1'b0, 2'b11);
        code(1'b1);
        code(1'b0);
        chk("R7", {63'd0, full_n}, 64'd0);
        for (int i = 0; i < 50; i++) take("R7", 64'(i + 100), 1'b0);
        chk("R7", {63'd0, full_n}, 64'd1);

        // R9 test mode pattern, FIFO untouched
        for (int i = 0; i < 3; i++) put(64'h7700 + 64'(i), 1'b1, 2'b11);
        test_n = 1'b0;
        for (int k = 0; k < 10; k++) take("R9", 64'(k), 1'b0);
        tick();
        chk("R9", tx_data, 64'd10);
        test_n = 1'b1;
        for (int i = 0; i < 3; i++) take("R9", 64'h7700 + 64'(i), 1'b1);
        chk("R9", {63'd0, tx_valid}, 64'd0);

        // R1 reset mid-run clears queue, stop state, overflow and counter
        for (int i = 0; i < 5; i++) put(64'(i), 1'b0, 2'b11);
        code(1'b1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #0.5;
        chk("R1", {63'd0, full_n}, 64'd1);
        chk("R1", {63'd0, tx_valid}, 64'd0);
        chk("R1", {63'd0, ovf}, 64'd0);
        test_n = 1'b0;
        #0.5;
        chk("R1", tx_data, 64'd0);
        test_n = 1'b1;
        tick();
        finish_run();
    end
endmodule